// File: doc/BRIEF.md
# Periodic Countdown Timer with Self-Releasing Interrupt

This block is a periodic countdown timer of the kind used inside a real-time clock. Software loads a 12-bit reload value and picks one of four tick sources: a 4096 Hz strobe, a 64 Hz strobe, the seconds-update event or the minutes-update event. While the run bit is set, each selected tick lowers the count by one. When the count runs out, the block sets a sticky status flag and loads the reload value again, so it expires again after the same number of ticks.

When the flag goes from 0 to 1 and the interrupt enable is set, the block asserts an active-low open-drain interrupt request. The request is modelled as one drive-low enable. The request releases itself after 32 ticks of the 4096 Hz strobe (about 7.8 ms). The flag stays set until an explicit clear strobe. Clearing the interrupt enable releases the request at once. The tick strobes arrive from outside as single-cycle pulses in the system clock domain.

Top module: `cdt_timer`

## Requirements
- R1: While reset is high, and after it is released, the flag is 0, the drive enable is 0 and the count is 0.
- R2: While the run bit is 0, the count takes the reload value at each clock edge, and tick strobes have no effect on it.
- R3: The source select decides which strobe counts: 00 picks the 4096 Hz strobe, 01 the 64 Hz strobe, 10 the seconds event and 11 the minutes event. Strobes that are not selected leave the count unchanged.
- R4: While running, a selected tick lowers a count above 1 by one. A selected tick at count 1 reloads the reload value and expires the timer. The period is therefore the reload value in ticks.
- R5: A reload value of 0 never expires the timer, and the count stays at 0.
- R6: An expiry sets the flag. The flag stays set until the clear strobe. If an expiry and the clear strobe fall in the same cycle, the flag is set.
- R7: The drive enable goes high at the same clock edge where the flag goes from 0 to 1, but only if the interrupt enable is 1. It does not go high when the flag was already 1 or when the interrupt enable is 0.
- R8: A 0 on the interrupt enable drives the drive enable to 0 at the next clock edge.
- R9: The drive enable goes to 0 by itself at the 32nd 4096 Hz strobe counted after it was asserted. The flag stays set.
- R10: After the run bit rises, the first selected tick already counts from the loaded value, so the first period can be up to one tick short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_4k | input | 1 | 4096 Hz strobe, one cycle wide |
| tick_64 | input | 1 | 64 Hz strobe, one cycle wide |
| tick_sec | input | 1 | Seconds-update strobe |
| tick_min | input | 1 | Minutes-update strobe |
| reload_val | input | 12 | Countdown reload value |
| src_sel | input | 2 | Tick source select |
| run_en | input | 1 | Countdown enable |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the sticky flag |
| flag | output | 1 | Sticky expiry flag |
| irq_drive | output | 1 | Drive-low enable for the open-drain interrupt pin |
| count | output | 12 | Current countdown value |

## Verification
The count is visible on a port, so a wrong internal count shows at the first clock edge after the selected tick that produced it. A broken reload shows one period later as an expiry at the wrong tick. The pulse counter cannot be seen directly. An error in it shows up only at the 32nd 4096 Hz strobe after assertion, either as a release that comes early or as a drive enable that stays high too long, so the bench counts those strobes one by one and checks the output before and after the last one. A wrong edge detect on the flag shows up as an interrupt request with no flag rise, or as a missing request on the first expiry after a clear.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int CNT_W       = 12;
    localparam int N_SRC       = 4;
    localparam int SEL_W       = $clog2(N_SRC);
    localparam int PULSE_TICKS = 32;

    typedef enum logic [SEL_W-1:0] {
        SRC_FAST   = 2'b00,
        SRC_SLOW   = 2'b01,
        SRC_SECOND = 2'b10,
        SRC_MINUTE = 2'b11
    } src_e;

    typedef struct packed {
        logic             expire;
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    function automatic logic is_last(input logic [CNT_W-1:0] c);
        return c == CNT_W'(1);
    endfunction
endpackage

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel
    import cdt_pkg::*;
(
    input  logic [N_SRC-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    always_comb begin
        case (src_e'(sel))
            SRC_FAST:   tick = ticks[0];
            SRC_SLOW:   tick = ticks[1];
            SRC_SECOND: tick = ticks[2];
            SRC_MINUTE: tick = ticks[3];
            default:    tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         tick,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic         live;

    assign live   = run_en && tick && (reload_val != '0);
    assign expire = live && (cnt_q == W'(1));
    assign count  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run_en) begin
            cnt_q <= reload_val;
        end else if (live) begin
            if (cnt_q <= W'(1)) cnt_q <= reload_val;
            else                cnt_q <= cnt_q - W'(1);
        end
    end

    AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> cnt_q == $past(reload_val)); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick && reload_val != '0 && cnt_q > W'(1)) |=> cnt_q == W'($past(cnt_q) - W'(1))); // R4
    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
        (run_en && reload_val == '0 && cnt_q == '0) |=> cnt_q == '0); // R5
endmodule

// File: rtl/cdt_irq_pulse.sv
module cdt_irq_pulse
    import cdt_pkg::*;
#(
    parameter int PULSE = PULSE_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic flag_clr,
    input  logic irq_en,
    input  logic tick_4k,
    output logic flag,
    output logic irq_drive
);
    localparam int PW = $clog2(PULSE + 1);

    logic          flag_q;
    logic          drv_q;
    logic [PW-1:0] pcnt_q;
    logic          event_w;

    assign event_w   = expire && !flag_q;
    assign flag      = flag_q;
    assign irq_drive = drv_q;

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (expire)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= 1'b0;
            pcnt_q <= '0;
        end else if (!irq_en) begin
            drv_q  <= 1'b0;
            pcnt_q <= '0;
        end else if (event_w) begin
            drv_q  <= 1'b1;
            pcnt_q <= '0;
        end else if (drv_q && tick_4k) begin
            if (pcnt_q == PW'(PULSE - 1)) begin
                drv_q  <= 1'b0;
                pcnt_q <= '0;
            end else begin
                pcnt_q <= pcnt_q + PW'(1);
            end
        end
    end

    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_q) |-> $rose(flag_q)); // R7
    AST_EN_DROP: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> !drv_q); // R8
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
        drv_q |-> pcnt_q < PW'(PULSE)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q); // R6
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_4k,
    input  logic             tick_64,
    input  logic             tick_sec,
    input  logic             tick_min,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             run_en,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             flag,
    output logic             irq_drive,
    output logic [CNT_W-1:0] count
);
    logic             sel_tick;
    cnt_state_t       cst;

    cdt_tick_sel u_sel (
        .ticks ({tick_min, tick_sec, tick_64, tick_4k}),
        .sel   (src_sel),
        .tick  (sel_tick)
    );

    cdt_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .tick       (sel_tick),
        .reload_val (reload_val),
        .count      (cst.value),
        .expire     (cst.expire)
    );

    cdt_irq_pulse #(.PULSE(PULSE_TICKS)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .expire    (cst.expire),
        .flag_clr  (flag_clr),
        .irq_en    (irq_en),
        .tick_4k   (tick_4k),
        .flag      (flag),
        .irq_drive (irq_drive)
    );

    assign count = cst.value;

    AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (run_en && sel_tick && is_last(cst.value) && reload_val != '0) |=> (flag && cst.value == $past(reload_val))); // R4
endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
    import cdt_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       tk = '0;
    logic [CNT_W-1:0] reload_val = '0;
    logic [SEL_W-1:0] src_sel = '0;
    logic             run_en = 1'b0;
    logic             irq_en = 1'b0;
    logic             flag_clr = 1'b0;
    logic             flag, irq_drive;
    logic [CNT_W-1:0] count;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cdt_timer u_dut (
        .clk(clk), .rst(rst),
        .tick_4k(tk[0]), .tick_64(tk[1]), .tick_sec(tk[2]), .tick_min(tk[3]),
        .reload_val(reload_val), .src_sel(src_sel), .run_en(run_en),
        .irq_en(irq_en), .flag_clr(flag_clr),
        .flag(flag), .irq_drive(irq_drive), .count(count)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [3:0] m);
        tk = m;
        @(negedge clk);
        tk = '0;
    endtask

    task automatic load(input int v, input int sel);
        run_en = 1'b0; reload_val = CNT_W'(v); src_sel = SEL_W'(sel);
        step();
        run_en = 1'b1;
    endtask

    task automatic t_reset();
        step(); step();
        chk("R1 flag in reset", flag, 0);
        chk("R1 irq in reset", irq_drive, 0);
        chk("R1 count in reset", count, 0);
        rst = 1'b0;
        step();
        chk("R1 flag after reset", flag, 0);
        chk("R1 irq after reset", irq_drive, 0);
    endtask

    task automatic t_idle();
        run_en = 1'b0; reload_val = 12'd5;
        step();
        chk("R2 idle load", count, 5);
        pulse(4'b1111);
        chk("R2 ticks ignored idle", count, 5);
        reload_val = 12'd4095;
        step();
        chk("R2 idle follows reload", count, 4095);
    endtask

    task automatic t_select();
        for (int s = 0; s < 4; s++) begin
            load(10, s);
            pulse(4'b1111 & ~(4'b0001 << s));
            chk("R3 unselected ignored", count, 10);
            pulse(4'b0001 << s);
            chk("R3 selected counts / R10 first tick", count, 9);
        end
    endtask

    task automatic t_period();
        irq_en = 1'b0;
        load(3, 0);
        pulse(4'b0001);
        chk("R4 down 1", count, 2);
        pulse(4'b0001);
        chk("R4 down 2", count, 1);
        chk("R4 no early flag", flag, 0);
        pulse(4'b0001);
        chk("R4 reload", count, 3);
        chk("R6 flag set", flag, 1);
        chk("R7 no irq when disabled", irq_drive, 0);
    endtask

    task automatic t_sticky();
        pulse(4'b0001);
        chk("R6 flag stays", flag, 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk("R6 flag cleared", flag, 0);
        load(1, 0);
        flag_clr = 1'b1; pulse(4'b0001); flag_clr = 1'b0;
        chk("R6 set wins over clear", flag, 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
    endtask

    task automatic t_irq_pulse();
        irq_en = 1'b1;
        load(2, 1);
        pulse(4'b0010);
        chk("R7 no irq before expiry", irq_drive, 0);
        pulse(4'b0010);
        chk("R7 irq on flag rise", irq_drive, 1);
        chk("R7 flag rose", flag, 1);
        for (int i = 0; i < 31; i++) pulse(4'b0001);
        chk("R9 still driven at 31", irq_drive, 1);
        pulse(4'b0001);
        chk("R9 auto release at 32", irq_drive, 0);
        chk("R9 flag kept", flag, 1);
    endtask

    task automatic t_flag_held();
        pulse(4'b0010); pulse(4'b0010);
        chk("R7 no irq when flag already set", irq_drive, 0);
        chk("R7 flag still set", flag, 1);
    endtask

    task automatic t_en_drop();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        pulse(4'b0010); pulse(4'b0010);
        chk("R8 irq asserted first", irq_drive, 1);
        irq_en = 1'b0;
        step();
        chk("R8 release on enable low", irq_drive, 0);
    endtask

    task automatic t_zero();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        load(0, 0);
        for (int i = 0; i < 5; i++) pulse(4'b0001);
        chk("R5 zero count", count, 0);
        chk("R5 zero no flag", flag, 0);
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_select();
        t_period();
        t_sticky();
        t_irq_pulse();
        t_flag_held();
        t_en_drop();
        t_zero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule